// File: doc/BRIEF.md
# Clock-Crossing Ping-Pong Frame Buffer

This block carries fixed-length frames of signed samples from a producer clock domain to a consumer clock domain. Storage is a dual-port memory sized for two frames. At any time one half belongs to the producer and the other half may belong to the consumer. The producer streams samples in with a valid strobe. When a frame is complete, ownership of that half passes to the consumer, and the producer moves on to the other half.

Ownership moves under a four-phase level handshake. The producer raises a request, together with a half-select bit that stays still for the whole request. The consumer answers with an acknowledge and presents the frame. The producer then drops its request. The consumer drops acknowledge only after it has reported the frame done and has seen the request low. Only the request and acknowledge wires cross between the domains, each through a chain of receiving-clock flops. The half-select bit and the memory contents are stable whenever they are used, so no data bus needs a synchronizer. One asynchronous reset input clears both domains, and each domain releases it on its own clock.

The consumer reads random-access by sample index with one cycle of latency. It signals the end of its work with a done strobe. If the producer completes a frame while a handover is still open, that frame is dropped, an overflow pulse is raised, and writing starts again in the producer's own half.

Top module: `pingpong_xfer`

## Requirements
- R1: After reset is released, `rd_frame_ready` and `wr_overflow` are low and `rd_data` reads zero.
- R2: Each run of FRAME_LEN accepted samples (`wr_valid` high on a `wr_clk` edge) forms one frame. Once delivered, sample k of the frame (k counted from 0 in acceptance order) is found at `rd_addr` = k with its value unchanged.
- R3: Frames reach the consumer in the order they were completed. No frame is duplicated, and every completed frame that did not overflow is delivered.
- R4: `rd_data` shows the sample at the address presented on the previous `rd_clk` edge, so the read latency is exactly one consumer clock.
- R5: While `rd_frame_ready` is low at a `rd_clk` edge, `rd_data` after that edge is zero. The half still held by the producer can never be read.
- R6: A `rd_done` strobe while `rd_frame_ready` is high makes `rd_frame_ready` low after the next `rd_clk` edge. A `rd_done` strobe while `rd_frame_ready` is low has no effect, and no later frame is lost.
- R7: The handshake keeps its four phases in order. Request rises only while the synchronized acknowledge is low. Acknowledge rises only after the synchronized request is high. Request falls only after the synchronized acknowledge is high. Acknowledge falls only while the synchronized request is low. `rd_frame_ready` is high only while acknowledge is high.
- R8: The half-select bit sent with a request does not change while the request is high.
- R9: A frame completed while a handover is still open (request high, or synchronized acknowledge high) raises `wr_overflow` for exactly one `wr_clk` cycle, starting at the edge that accepted its last sample. That frame is discarded, and the frame held by the consumer is not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| arst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_clk | input | 1 | Producer clock |
| wr_valid | input | 1 | Sample strobe, one sample accepted per high edge |
| wr_data | input | DATA_W | Signed sample written when `wr_valid` is high |
| wr_overflow | output | 1 | One-cycle pulse when a completed frame is dropped |
| rd_clk | input | 1 | Consumer clock |
| rd_addr | input | $clog2(FRAME_LEN) | Sample index within the presented frame |
| rd_data | output | DATA_W | Signed sample, one cycle after its address |
| rd_frame_ready | output | 1 | A complete frame is held for the consumer |
| rd_done | input | 1 | Consumer strobe that releases the presented frame |

## Verification
The bench builds the block with its defaults: 16-bit samples, 32-sample frames and two-flop synchronizers. With these values, a frame on a 100 MHz producer lasts long enough for both a faster consumer (35:20 ratio) and a slower one (20:35 ratio) to finish or fall behind. The bench covers both ratios, so handovers occur with and without a consumer that lags. A short frame also lets a directed phase complete several frames while the consumer deliberately sits on one. This makes overflow drops and their effect on ordering easy to reach. The two-flop depth keeps the handshake round trip short compared with a frame, so the check on the request, acknowledge and half-select phases sees many full cycles.

// File: rtl/pp_pkg.sv
package pp_pkg;
    // Reader ownership phases of the consumer side
    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,   // nothing held, acknowledge low
        RD_HOLD  = 2'd1,   // frame presented to consumer
        RD_DRAIN = 2'd2    // frame released, waiting for request to fall
    } rd_phase_e;
endpackage

// File: rtl/pp_sync.sv
module pp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/pp_dpram.sv
module pp_dpram #(
    parameter int W  = 16,
    parameter int AW = 6
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          rclk,
    input  logic          rrst_n,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];
    logic [W-1:0] rdata_q;

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Reads outside an owned half return zero
    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n)  rdata_q <= '0;
        else if (re)  rdata_q <= mem[raddr];
        else          rdata_q <= '0;
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/pp_wr_ctrl.sv
module pp_wr_ctrl #(
    parameter int FRAME_LEN = 32,
    localparam int AW = $clog2(FRAME_LEN)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        ack_s,
    output logic        mem_we,
    output logic [AW:0] mem_addr,
    output logic        req,
    output logic        sel,
    output logic        overflow
);
    localparam logic [AW-1:0] LAST_IDX = AW'(FRAME_LEN - 1);

    typedef struct packed {
        logic          half;   // half being filled
        logic [AW-1:0] idx;    // next sample index
        logic          req;
        logic          sel;    // half offered with req
        logic          ovf;
    } wr_state_t;

    wr_state_t s_d, s_q;
    logic      busy;

    assign busy = s_q.req | ack_s;

    always_comb begin
        s_d     = s_q;
        s_d.ovf = 1'b0;
        if (s_q.req && ack_s) s_d.req = 1'b0;
        if (in_valid) begin
            if (s_q.idx == LAST_IDX) begin
                s_d.idx = '0;
                if (!busy) begin
                    s_d.req  = 1'b1;
                    s_d.sel  = s_q.half;
                    s_d.half = ~s_q.half;
                end else begin
                    s_d.ovf = 1'b1;
                end
            end else begin
                s_d.idx = s_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mem_we   = in_valid;
    assign mem_addr = {s_q.half, s_q.idx};
    assign req      = s_q.req;
    assign sel      = s_q.sel;
    assign overflow = s_q.ovf;
endmodule

// File: rtl/pp_rd_ctrl.sv
module pp_rd_ctrl
    import pp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_s,
    input  logic sel_in,
    input  logic done,
    output logic ack,
    output logic ready,
    output logic half
);
    typedef struct packed {
        rd_phase_e ph;
        logic      half;
    } rd_state_t;

    rd_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (s_q.ph)
            RD_IDLE: begin
                if (req_s) begin
                    s_d.ph   = RD_HOLD;
                    s_d.half = sel_in;
                end
            end
            RD_HOLD: begin
                if (done) s_d.ph = req_s ? RD_DRAIN : RD_IDLE;
            end
            RD_DRAIN: begin
                if (!req_s) s_d.ph = RD_IDLE;
            end
            default: s_d.ph = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{ph: RD_IDLE, half: 1'b0};
        else        s_q <= s_d;
    end

    assign ack   = (s_q.ph != RD_IDLE);
    assign ready = (s_q.ph == RD_HOLD);
    assign half  = s_q.half;
endmodule

// File: rtl/pingpong_xfer.sv
module pingpong_xfer #(
    parameter int DATA_W      = 16,
    parameter int FRAME_LEN   = 32,
    parameter int SYNC_STAGES = 2,
    localparam int AW = $clog2(FRAME_LEN)
) (
    input  logic                     arst_n,
    input  logic                     wr_clk,
    input  logic                     wr_valid,
    input  logic signed [DATA_W-1:0] wr_data,
    output logic                     wr_overflow,
    input  logic                     rd_clk,
    input  logic [AW-1:0]            rd_addr,
    output logic signed [DATA_W-1:0] rd_data,
    output logic                     rd_frame_ready,
    input  logic                     rd_done
);
    logic          wr_rst_n, rd_rst_n;
    logic          req, req_s, ack, ack_s, sel;
    logic          mem_we, rd_half;
    logic [AW:0]   mem_waddr;
    logic [DATA_W-1:0] rdata_raw;

    // Reset: asserted at once, released on each domain's clock
    pp_sync #(.STAGES(SYNC_STAGES)) u_wr_rst (
        .clk(wr_clk), .rst_n(arst_n), .d(1'b1), .q(wr_rst_n));
    pp_sync #(.STAGES(SYNC_STAGES)) u_rd_rst (
        .clk(rd_clk), .rst_n(arst_n), .d(1'b1), .q(rd_rst_n));

    // Handshake crossings
    pp_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk(rd_clk), .rst_n(rd_rst_n), .d(req), .q(req_s));
    pp_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(wr_clk), .rst_n(wr_rst_n), .d(ack), .q(ack_s));

    pp_wr_ctrl #(.FRAME_LEN(FRAME_LEN)) u_wr (
        .clk(wr_clk), .rst_n(wr_rst_n), .in_valid(wr_valid), .ack_s(ack_s),
        .mem_we(mem_we), .mem_addr(mem_waddr), .req(req), .sel(sel),
        .overflow(wr_overflow));

    pp_rd_ctrl u_rd (
        .clk(rd_clk), .rst_n(rd_rst_n), .req_s(req_s), .sel_in(sel),
        .done(rd_done), .ack(ack), .ready(rd_frame_ready), .half(rd_half));

    pp_dpram #(.W(DATA_W), .AW(AW + 1)) u_mem (
        .wclk(wr_clk), .we(mem_we), .waddr(mem_waddr), .wdata(wr_data),
        .rclk(rd_clk), .rrst_n(rd_rst_n), .re(rd_frame_ready),
        .raddr({rd_half, rd_addr}), .rdata(rdata_raw));

    assign rd_data = rdata_raw;
endmodule

// File: rtl/pp_xfer_chk.sv
module pp_xfer_chk #(
    parameter int DATA_W = 16
) (
    input logic              wr_clk,
    input logic              rd_clk,
    input logic              wr_rst_n,
    input logic              rd_rst_n,
    input logic              req,
    input logic              req_s,
    input logic              ack,
    input logic              ack_s,
    input logic              sel,
    input logic              wr_valid,
    input logic              wr_overflow,
    input logic              rd_frame_ready,
    input logic [DATA_W-1:0] rd_data
);
    // R7
    req_rise_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        $rose(req) |-> !ack_s);
    // R7
    req_fall_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        $fell(req) |-> ack_s);
    // R7
    ack_rise_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        $rose(ack) |-> req_s);
    // R7
    ack_fall_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        $fell(ack) |-> !req_s);
    // R7
    ready_ack_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_frame_ready |-> ack);
    // R8
    sel_hold_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        req |=> $stable(sel));
    // R5
    unread_zero_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        !rd_frame_ready |=> (rd_data == '0));
    // R9
    ovf_pulse_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        wr_overflow |=> !wr_overflow);
    // R9
    ovf_cause_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        wr_overflow |-> $past(wr_valid));
endmodule

bind pingpong_xfer pp_xfer_chk #(.DATA_W(DATA_W)) u_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .wr_rst_n(wr_rst_n), .rd_rst_n(rd_rst_n),
    .req(req), .req_s(req_s), .ack(ack), .ack_s(ack_s), .sel(sel),
    .wr_valid(wr_valid), .wr_overflow(wr_overflow),
    .rd_frame_ready(rd_frame_ready), .rd_data(rd_data));

// File: tb/tb_pingpong_xfer.sv
`timescale 1ns/1ps
module tb_pingpong_xfer;
    localparam int DW  = 16;
    localparam int LEN = 32;
    localparam int AW  = 5;

    logic                 arst_n, wr_clk, rd_clk, wr_valid, wr_overflow;
    logic signed [DW-1:0] wr_data, rd_data;
    logic [AW-1:0]        rd_addr;
    logic                 rd_frame_ready, rd_done;

    real rd_half = 2.857;
    int  n_checks = 0, n_err = 0;
    int  tx_frames = 0, rx_frames = 0, ovf_count = 0;
    int  hold_cyc = 0, wd_cycles = 0;
    bit  rst_done = 0;
    logic [DW-1:0] exp_q[$];

    pingpong_xfer #(.DATA_W(DW), .FRAME_LEN(LEN), .SYNC_STAGES(2)) dut (
        .arst_n(arst_n), .wr_clk(wr_clk), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_overflow(wr_overflow), .rd_clk(rd_clk), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_frame_ready(rd_frame_ready), .rd_done(rd_done));

    initial begin wr_clk = 0; forever #5 wr_clk = ~wr_clk; end
    initial begin rd_clk = 0; forever #(rd_half) rd_clk = ~rd_clk; end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    endtask

    initial begin : watchdog
        forever begin
            @(posedge wr_clk);
            wd_cycles++;
            if (wd_cycles > 150000) begin
                check(0, "R3 watchdog expired", wd_cycles, 150000);
                finish_run();
            end
        end
    end

    // Sends one frame; pattern 0 random, 1 extremes. Returns nothing; models R9.
    task automatic send_frame(input int gap_pct, input int pattern);
        logic [DW-1:0] f [LEN];
        for (int i = 0; i < LEN; i++)
            f[i] = (pattern == 1) ? ((i % 2 == 0) ? 16'h8000 : 16'h7FFF)
                                  : DW'($urandom & 32'hFFFF);
        for (int i = 0; i < LEN; i++) begin
            while (($urandom % 100) < gap_pct) begin
                wr_valid = 0;
                @(negedge wr_clk);
                check(wr_overflow == 0, "R9 no mid-frame overflow", wr_overflow, 0);
            end
            wr_valid = 1;
            wr_data  = f[i];
            @(negedge wr_clk);
            if (i != LEN - 1)
                check(wr_overflow == 0, "R9 no mid-frame overflow", wr_overflow, 0);
        end
        wr_valid = 0;
        if (wr_overflow) ovf_count++;
        else begin
            for (int i = 0; i < LEN; i++) exp_q.push_back(f[i]);
            tx_frames++;
        end
        @(negedge wr_clk);
        check(wr_overflow == 0, "R9 overflow lasts one cycle", wr_overflow, 0);
    endtask

    task automatic wait_drain();
        for (int n = 0; n < 20000 && rx_frames != tx_frames; n++) @(negedge wr_clk);
        check(rx_frames == tx_frames, "R3 all frames delivered", rx_frames, tx_frames);
    endtask

    initial begin : consumer
        logic [DW-1:0] fr [LEN];
        int a;
        rd_addr = '0;
        rd_done = 0;
        wait (rst_done);
        @(negedge rd_clk);
        // R6: done with nothing presented is ignored
        rd_done = 1;
        @(negedge rd_clk);
        rd_done = 0;
        @(negedge rd_clk);
        check(rd_frame_ready == 0, "R6 stray done ignored", rd_frame_ready, 0);
        forever begin
            while (!rd_frame_ready) begin
                @(negedge rd_clk);
                check(rd_data == 0, "R5 unowned half reads zero", rd_data, 0);
            end
            if (exp_q.size() < LEN) begin
                check(0, "R3 unexpected frame", exp_q.size(), LEN);
                for (int i = 0; i < LEN; i++) fr[i] = '0;
            end else begin
                for (int i = 0; i < LEN; i++) fr[i] = exp_q.pop_front();
            end
            for (int k = 0; k < LEN; k++) begin
                a = (rx_frames % 2 == 1) ? (LEN - 1 - k) : k;
                rd_addr = AW'(a);
                @(negedge rd_clk);
                // R4: data one edge after address
                check(rd_data == fr[a], "R2 R3 R4 sample value", rd_data, $signed(fr[a]));
                if (($urandom % 4) == 0) begin
                    @(negedge rd_clk);
                    check(rd_data == fr[a], "R4 held address", rd_data, $signed(fr[a]));
                end
            end
            for (int h = 0; h < hold_cyc; h++) @(negedge rd_clk);
            check(rd_frame_ready == 1, "R6 frame held until done", rd_frame_ready, 1);
            rd_done = 1;
            @(negedge rd_clk);
            rd_done = 0;
            check(rd_frame_ready == 0, "R6 done releases frame", rd_frame_ready, 0);
            rx_frames++;
        end
    end

    initial begin : main
        int ovf_before;
        void'($urandom(32'd20240917));
        arst_n = 0; wr_valid = 0; wr_data = '0;
        #53 arst_n = 1;
        repeat (6) @(negedge wr_clk);
        // R1
        check(wr_overflow == 0, "R1 overflow after reset", wr_overflow, 0);
        check(rd_frame_ready == 0, "R1 ready after reset", rd_frame_ready, 0);
        check(rd_data == 0, "R1 data after reset", rd_data, 0);
        rst_done = 1;
        repeat (4) @(negedge wr_clk);

        // Consumer faster (35:20)
        send_frame(0, 1);
        for (int f = 0; f < 7; f++) send_frame(20, 0);
        wait_drain();

        // Consumer slower (20:35)
        rd_half = 8.75;
        for (int f = 0; f < 8; f++) send_frame(10, 0);
        wait_drain();

        // Directed overflow: consumer sits on one frame
        rd_half = 2.857;
        repeat (20) @(negedge wr_clk);
        hold_cyc   = 600;
        ovf_before = ovf_count;
        for (int f = 0; f < 4; f++) send_frame(0, 0);
        check(ovf_count - ovf_before == 3, "R9 frames dropped while held",
              ovf_count - ovf_before, 3);
        wait_drain();
        hold_cyc = 0;

        // Delivery resumes after drops
        for (int f = 0; f < 2; f++) send_frame(5, 0);
        wait_drain();
        check(exp_q.size() == 0, "R3 no frame left pending", exp_q.size(), 0);
        finish_run();
    end
endmodule